// File: doc/BRIEF.md
# Demodulator Lock Supervisor

This block follows the acquisition progress of a phase-shift-keyed demodulator. Each clock it samples four status levels: carrier recovered, symbol timing recovered, front-end gain settled, digital gain settled. It also samples a confirmation level from the downstream error-correcting decoder. A three-state controller moves from searching, to a provisional carrier-and-timing lock, to a confirmed full lock. The provisional state lasts only for a programmable window. If the decoder does not confirm within that window, the controller gives up the provisional lock and asks the acquisition logic to search again.

Every acquisition and loss is recorded as a sticky bit in one of two byte-wide event registers. A read through a small register port returns the addressed byte and clears it on the same edge. Any event that arrives on that edge is kept. A per-bit enable mask over the sixteen event positions forms a single interrupt line.

Top module: `qlock_supervisor`

## Requirements
- R1: The provisional state is entered from searching only when carrier and timing levels are both high in the same cycle. `lock_state_o` encodes 0 for searching, 1 for provisional and 2 for full lock.
- R2: In the provisional state, a high decoder confirmation moves the controller to full lock on the next edge.
- R3: With confirmation absent and carrier and timing held, the provisional state is left on the edge after `wait_cfg_i`*1024 + 1 edges spent in it. A value of 0 therefore allows one edge only.
- R4: Losing carrier or timing in the provisional or full-lock state returns the controller to searching on the next edge. `restart_o` is high for exactly the cycle after that edge.
- R5: A window expiry also raises `restart_o` for one cycle and logs a provisional-unlock event.
- R6: Event byte 0 holds, from bit 0 upward: carrier lock, carrier unlock, timing lock, timing unlock, provisional lock, provisional unlock, full lock, full unlock. Event byte 1 holds front-end gain lock in bit 0, digital gain lock in bit 1 and digital gain unlock in bit 2. Bits 7..3 of byte 1 always read 0. Both bytes are 0x00 after reset.
- R7: A read (`rd_en_i` high) returns the addressed byte on `rd_data_o` in the same cycle and clears only that byte at the edge. The other byte keeps its contents.
- R8: An event that occurs on the same edge as the clearing read of its byte is kept and is readable afterwards.
- R9: `irq_o` is high exactly when some event bit is set whose enable bit is set. Enable bit i covers byte i/8, bit i%8.
- R10: Lock events fire on rising levels and unlock events on falling levels. A falling front-end gain level logs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_ok_i | input | 1 | Carrier recovered level |
| timing_ok_i | input | 1 | Symbol timing recovered level |
| fe_agc_ok_i | input | 1 | Front-end gain settled level |
| dig_agc_ok_i | input | 1 | Digital gain settled level |
| fec_ok_i | input | 1 | Decoder confirmation level |
| wait_cfg_i | input | 8 | Confirmation window in units of 1024 cycles |
| irq_mask_i | input | 16 | Per-event interrupt enable |
| rd_en_i | input | 1 | Read strobe, clears the addressed byte |
| rd_addr_i | input | 1 | Event byte select |
| rd_data_o | output | 8 | Addressed event byte |
| lock_state_o | output | 2 | Controller state |
| restart_o | output | 1 | One-cycle search restart request |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench measures the confirmation window to the exact edge for settings 1 and 0. A counter that is off by one would leave the provisional state one cycle early or late, and a zero setting misread as the maximum would hang in it. It makes an event coincide with the clearing read of its own byte. A clear-wins priority would lose that event. It also checks that the neighbouring byte survives the read, that a front-end gain drop logs nothing, and that the interrupt follows the mask. Wrong priority or a swapped bit position would show as a wrong byte value.

// File: rtl/qls_pkg.sv
package qls_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_CTLOCK = 2'd1,
        ST_LOCKED = 2'd2
    } lk_state_e;

    localparam int EVT_BYTES = 2;
    localparam int EVT_BITS  = EVT_BYTES * 8;
endpackage

// File: rtl/edge_watch.sv
module edge_watch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/evt_byte.sv
module evt_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = (clr_i ? '0 : bits_q) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q_o = bits_q;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> bits_q == '0); // R7
    AST_SET_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (bits_q & $past(set_i)) == $past(set_i)); // R8
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import qls_pkg::*;
#(
    parameter int CFG_W = 8,
    parameter int SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ct_ok_i,
    input  logic             fec_ok_i,
    input  logic [CFG_W-1:0] wait_cfg_i,
    output lk_state_e        state_o,
    output logic             restart_o,
    output logic             ct_lock_ev_o,
    output logic             ct_unlock_ev_o,
    output logic             full_lock_ev_o,
    output logic             full_unlock_ev_o
);
    localparam int CNT_W = CFG_W + SHIFT;

    typedef struct packed {
        lk_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             restart;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d              = r_q;
        r_d.restart      = 1'b0;
        ct_lock_ev_o     = 1'b0;
        ct_unlock_ev_o   = 1'b0;
        full_lock_ev_o   = 1'b0;
        full_unlock_ev_o = 1'b0;
        unique case (r_q.state)
            ST_SEARCH: begin
                if (ct_ok_i) begin
                    r_d.state    = ST_CTLOCK;
                    r_d.cnt      = CNT_W'(wait_cfg_i) << SHIFT;
                    ct_lock_ev_o = 1'b1;
                end
            end
            ST_CTLOCK: begin
                if (!ct_ok_i || (!fec_ok_i && r_q.cnt == '0)) begin
                    r_d.state      = ST_SEARCH;
                    r_d.restart    = 1'b1;
                    ct_unlock_ev_o = 1'b1;
                end else if (fec_ok_i) begin
                    r_d.state      = ST_LOCKED;
                    full_lock_ev_o = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_LOCKED: begin
                if (!ct_ok_i) begin
                    r_d.state        = ST_SEARCH;
                    r_d.restart      = 1'b1;
                    ct_unlock_ev_o   = 1'b1;
                    full_unlock_ev_o = 1'b1;
                end
            end
            default: r_d.state = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_SEARCH;
            r_q.cnt     <= '0;
            r_q.restart <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.state;
    assign restart_o = r_q.restart;

    AST_SEARCH_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SEARCH && !ct_ok_i) |=> r_q.state == ST_SEARCH); // R1
    AST_LOCK_VIA_CT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOCKED) |-> ($past(r_q.state) != ST_SEARCH)); // R2
    AST_DROP_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_SEARCH && !ct_ok_i) |=> (r_q.state == ST_SEARCH && r_q.restart)); // R4
    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.restart |=> !r_q.restart); // R4
    AST_EXPIRY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CTLOCK && ct_ok_i && !fec_ok_i && r_q.cnt == '0) |=> r_q.restart); // R5
endmodule

// File: rtl/qlock_supervisor.sv
module qlock_supervisor
    import qls_pkg::*;
#(
    parameter int CFG_W = 8,
    parameter int SHIFT = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          carrier_ok_i,
    input  logic                          timing_ok_i,
    input  logic                          fe_agc_ok_i,
    input  logic                          dig_agc_ok_i,
    input  logic                          fec_ok_i,
    input  logic [CFG_W-1:0]              wait_cfg_i,
    input  logic [EVT_BITS-1:0]           irq_mask_i,
    input  logic                          rd_en_i,
    input  logic [$clog2(EVT_BYTES)-1:0]  rd_addr_i,
    output logic [7:0]                    rd_data_o,
    output logic [1:0]                    lock_state_o,
    output logic                          restart_o,
    output logic                          irq_o
);
    localparam int AW = $clog2(EVT_BYTES);

    logic [3:0]          lvl, rise, fall;
    lk_state_e           state;
    logic                ct_lk, ct_ul, fl_lk, fl_ul;
    logic [EVT_BITS-1:0] set_all;
    logic [7:0]          evt_q [EVT_BYTES];

    assign lvl = {dig_agc_ok_i, fe_agc_ok_i, timing_ok_i, carrier_ok_i};

    edge_watch #(.N(4)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    lock_fsm #(.CFG_W(CFG_W), .SHIFT(SHIFT)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .ct_ok_i          (carrier_ok_i & timing_ok_i),
        .fec_ok_i         (fec_ok_i),
        .wait_cfg_i       (wait_cfg_i),
        .state_o          (state),
        .restart_o        (restart_o),
        .ct_lock_ev_o     (ct_lk),
        .ct_unlock_ev_o   (ct_ul),
        .full_lock_ev_o   (fl_lk),
        .full_unlock_ev_o (fl_ul)
    );

    assign set_all[7:0]  = {fl_ul, fl_lk, ct_ul, ct_lk, fall[1], rise[1], fall[0], rise[0]};
    assign set_all[15:8] = {5'b0, fall[3], rise[3], rise[2]};

    for (genvar g = 0; g < EVT_BYTES; g++) begin : g_evt
        evt_byte #(.W(8)) u_byte (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_all[g*8 +: 8]),
            .clr_i (rd_en_i && rd_addr_i == AW'(g)),
            .q_o   (evt_q[g])
        );
    end

    always_comb begin
        irq_o = 1'b0;
        for (int b = 0; b < EVT_BYTES; b++) begin
            irq_o = irq_o | (|(evt_q[b] & irq_mask_i[b*8 +: 8]));
        end
    end

    assign rd_data_o    = evt_q[rd_addr_i];
    assign lock_state_o = state;

    AST_RSVD_STAY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q[1][7:3] == 5'b0); // R6
endmodule

// File: tb/tb_qlock_supervisor.sv
module tb_qlock_supervisor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        carrier_ok_i = 1'b0, timing_ok_i = 1'b0;
    logic        fe_agc_ok_i = 1'b0, dig_agc_ok_i = 1'b0, fec_ok_i = 1'b0;
    logic [7:0]  wait_cfg_i = 8'd0;
    logic [15:0] irq_mask_i = 16'd0;
    logic        rd_en_i = 1'b0;
    logic [0:0]  rd_addr_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic [1:0]  lock_state_o;
    logic        restart_o, irq_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qlock_supervisor dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input bit a, output logic [7:0] v);
        rd_en_i = 1'b1;
        rd_addr_i = a;
        #1 v = rd_data_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R6 state", lock_state_o, 0);
        chk("R4 restart", restart_o, 0);
        chk("R9 irq", irq_o, 0);
        rd(0, v); chk("R6 byte0 reset", v, 8'h00);
        rd(1, v); chk("R6 byte1 reset", v, 8'h00);
    endtask

    task automatic t_partial();
        logic [7:0] v;
        carrier_ok_i = 1;
        repeat (3) @(negedge clk);
        chk("R1 carrier only", lock_state_o, 0);
        rd(0, v); chk("R10 carrier lock", v, 8'h01);
        carrier_ok_i = 0;
        @(negedge clk);
        rd(0, v); chk("R10 carrier unlock", v, 8'h02);
    endtask

    task automatic t_lock_and_loss();
        logic [7:0] v;
        wait_cfg_i = 8'd4;
        carrier_ok_i = 1; timing_ok_i = 1;
        @(negedge clk);
        chk("R1 provisional", lock_state_o, 1);
        fec_ok_i = 1;
        @(negedge clk);
        chk("R2 full lock", lock_state_o, 2);
        rd(0, v); chk("R6 lock events", v, 8'h55);
        timing_ok_i = 0;
        @(negedge clk);
        chk("R4 back to search", lock_state_o, 0);
        chk("R4 restart high", restart_o, 1);
        @(negedge clk);
        chk("R4 restart one cycle", restart_o, 0);
        rd(0, v); chk("R4 unlock events", v, 8'hA8);
        carrier_ok_i = 0; fec_ok_i = 0;
        @(negedge clk);
        rd(0, v); chk("R10 carrier drop", v, 8'h02);
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        wait_cfg_i = 8'd1;
        carrier_ok_i = 1; timing_ok_i = 1;
        @(negedge clk);
        chk("R3 entered", lock_state_o, 1);
        repeat (1024) @(negedge clk);
        chk("R3 still waiting", lock_state_o, 1);
        chk("R3 no early restart", restart_o, 0);
        @(negedge clk);
        chk("R3 expired", lock_state_o, 0);
        chk("R5 restart on expiry", restart_o, 1);
        carrier_ok_i = 0; timing_ok_i = 0;
        @(negedge clk);
        rd(0, v); chk("R5 expiry events", v, 8'h3F);
    endtask

    task automatic t_zero_window();
        logic [7:0] v;
        wait_cfg_i = 8'd0;
        carrier_ok_i = 1; timing_ok_i = 1;
        @(negedge clk);
        chk("R3 zero entered", lock_state_o, 1);
        @(negedge clk);
        chk("R3 zero expired", lock_state_o, 0);
        chk("R5 zero restart", restart_o, 1);
        carrier_ok_i = 0; timing_ok_i = 0;
        @(negedge clk);
        rd(0, v); chk("R5 zero events", v, 8'h3F);
        carrier_ok_i = 1; timing_ok_i = 1; fec_ok_i = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 zero window confirm", lock_state_o, 2);
        carrier_ok_i = 0; timing_ok_i = 0; fec_ok_i = 0;
        @(negedge clk);
        chk("R4 drop from lock", lock_state_o, 0);
        rd(0, v); chk("R6 all byte0", v, 8'hFF);
    endtask

    task automatic t_agc();
        logic [7:0] v;
        fe_agc_ok_i = 1; dig_agc_ok_i = 1;
        @(negedge clk);
        rd(1, v); chk("R10 gain locks", v, 8'h03);
        fe_agc_ok_i = 0; dig_agc_ok_i = 0;
        @(negedge clk);
        rd(1, v); chk("R10 fe drop silent", v, 8'h04);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        fe_agc_ok_i = 1; carrier_ok_i = 1;
        @(negedge clk);
        carrier_ok_i = 0;
        rd(0, v); chk("R7 read value", v, 8'h01);
        rd(0, v); chk("R8 kept on read", v, 8'h02);
        rd(1, v); chk("R7 other byte kept", v, 8'h01);
        fe_agc_ok_i = 0;
        @(negedge clk);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        dig_agc_ok_i = 1;
        @(negedge clk);
        chk("R9 masked", irq_o, 0);
        irq_mask_i = 16'h0200;
        #1 chk("R9 enabled", irq_o, 1);
        irq_mask_i = 16'h0001;
        #1 chk("R9 other mask", irq_o, 0);
        irq_mask_i = 16'h0200;
        rd(1, v); chk("R9 read value", v, 8'h02);
        chk("R9 cleared", irq_o, 0);
        dig_agc_ok_i = 0;
        @(negedge clk);
        rd(1, v); chk("R10 dig unlock", v, 8'h04);
        irq_mask_i = 16'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_partial();
        t_lock_and_loss();
        t_timeout();
        t_zero_window();
        t_agc();
        t_collision();
        t_irq();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule